// File: doc/BRIEF.md
# Linked Dual Pulse-Count Divider

This block holds two channels that thin a stream of digital pulses. Each channel counts low-to-high transitions on its pulse input and passes one of every N of them to its output, where N is a per-channel divide factor from 1 to 16. The factor is stepped up or down by one per button press. Setting it to 1 passes every pulse through unchanged. The output pulse is the selected input pulse itself, delayed by a fixed number of clocks, so the block never moves a pulse in time. It only drops pulses.

A reset input does not clear the output at once. It arms a pending restart, and the next input pulse is then treated as the first of a new group. A link control lets channel two run from channel one's pulse and reset inputs, so that one source drives both dividers with different factors. Two per-input "patched" flags on channel two each bring back channel two's own input, one input at a time.

All inputs are asynchronous levels. Each passes through a synchroniser of SYNC_STAGES flops. There is no data stream here: every pin is a plain control or status level, with no valid/ready handshake and no back-pressure.

Top module: `pdiv_dual`

## Requirements
- R1: Each factor output holds a value between 1 and MAX_FACTOR (16). Each factor loads DEFAULT_FACTOR (2) while rst_n is low.
- R2: With factor N, one output pulse is produced for every N rising edges of the channel's effective pulse level. The output goes high 3 clocks after the raw input goes high (with SYNC_STAGES = 2) and falls 3 clocks after the raw input falls.
- R3: With a factor of 1, every input pulse appears at the output.
- R4: A rising edge on up raises the factor by one, and a rising edge on down lowers it by one. The edges are taken after synchronisation. If both edges arrive in the same cycle, the factor does not change.
- R5: The factor saturates: up has no effect at 16, and down has no effect at 1.
- R6: While the reset level is high, a restart is armed. The next input pulse is then output as the first of a group, the restart is disarmed, and counting resumes from that pulse.
- R7: If the factor is lowered to a value at or below the current count, the next input pulse is output.
- R8: When link_i is high, channel two uses channel one's pulse and reset levels in place of its own.
- R9: When link_i is high, b_pulse_patched_i brings back channel two's own pulse input, and b_reset_patched_i brings back channel two's own reset input. Each flag acts on its input alone.
- R10: If a reset level and a pulse rising edge are seen in the same cycle, that pulse uses the restart state from before the reset, and the reset arms a restart for the following pulse.
- R11: A synchronous active-low rst_n drives both outputs low, clears the counts and any armed restart, and loads the default factors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_i | input | 1 | Route channel one's pulse and reset inputs to channel two |
| b_pulse_patched_i | input | 1 | Channel two uses its own pulse input even when linked |
| b_reset_patched_i | input | 1 | Channel two uses its own reset input even when linked |
| a_pulse_i | input | 1 | Channel one pulse level |
| a_reset_i | input | 1 | Channel one restart request level |
| a_up_i | input | 1 | Channel one factor up button |
| a_down_i | input | 1 | Channel one factor down button |
| b_pulse_i | input | 1 | Channel two pulse level |
| b_reset_i | input | 1 | Channel two restart request level |
| b_up_i | input | 1 | Channel two factor up button |
| b_down_i | input | 1 | Channel two factor down button |
| a_out_o | output | 1 | Channel one divided output |
| b_out_o | output | 1 | Channel two divided output |
| a_factor_o | output | 5 | Channel one divide factor |
| b_factor_o | output | 5 | Channel two divide factor |

## Verification
The delicate overlap is a restart request and a pulse edge arriving in the same cycle. The bench provokes it by raising the raw reset and pulse levels on the same clock. It expects no output from that pulse, because the count is mid-group and no restart was armed before it. It then expects the following pulse to be output, because the same request armed a restart. A second overlap, a factor change that lands at or below a count in progress, is judged by requiring an output on the very next pulse. A behavioural model compares every output on every clock throughout.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  // Synchronised control levels seen by one divider channel
  typedef struct packed {
    logic pulse;
    logic restart;
    logic up;
    logic down;
  } pdiv_ctl_t;

  localparam int unsigned RAW_W = 11;
endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pdiv_factor.sv
module pdiv_factor #(
  parameter int unsigned MAX_FACTOR     = 16,
  parameter int unsigned DEFAULT_FACTOR = 2,
  localparam int unsigned FW            = $clog2(MAX_FACTOR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_lvl,
  input  logic          down_lvl,
  output logic [FW-1:0] factor_o
);
  logic up_q, down_q;
  logic up_edge, down_edge;
  logic [FW-1:0] fac_q;

  assign up_edge   = up_lvl & ~up_q;
  assign down_edge = down_lvl & ~down_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      down_q <= 1'b0;
      fac_q  <= FW'(DEFAULT_FACTOR);
    end else begin
      up_q   <= up_lvl;
      down_q <= down_lvl;
      if (up_edge && !down_edge && fac_q < FW'(MAX_FACTOR))
        fac_q <= fac_q + 1'b1;
      else if (down_edge && !up_edge && fac_q > FW'(1))
        fac_q <= fac_q - 1'b1;
    end
  end

  assign factor_o = fac_q;
endmodule

// File: rtl/pdiv_count.sv
module pdiv_count #(
  parameter int unsigned MAX_FACTOR = 16,
  localparam int unsigned FW        = $clog2(MAX_FACTOR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_lvl,
  input  logic          restart_lvl,
  input  logic [FW-1:0] factor_i,
  output logic          out_o
);
  logic          pulse_q;
  logic          armed_q;
  logic          gate_q;
  logic [FW-1:0] cnt_q;
  logic          edge_seen;
  logic [FW-1:0] slot;
  logic [FW-1:0] slot_next;

  assign edge_seen = pulse_lvl & ~pulse_q;

  always_comb begin
    // An armed restart or a factor lowered under the count both restart the group
    if (armed_q || cnt_q >= factor_i) slot = '0;
    else                              slot = cnt_q;
    slot_next = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= pulse_lvl;
      armed_q <= restart_lvl | (armed_q & ~edge_seen);
      if (edge_seen) begin
        gate_q <= (slot == '0);
        cnt_q  <= (slot_next >= factor_i) ? '0 : slot_next;
      end else begin
        gate_q <= gate_q & pulse_lvl;
      end
    end
  end

  assign out_o = gate_q;
endmodule

// File: rtl/pdiv_channel.sv
module pdiv_channel
  import pdiv_pkg::*;
#(
  parameter int unsigned MAX_FACTOR     = 16,
  parameter int unsigned DEFAULT_FACTOR = 2,
  localparam int unsigned FW            = $clog2(MAX_FACTOR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pdiv_ctl_t     ctl_i,
  output logic          out_o,
  output logic [FW-1:0] factor_o
);
  logic [FW-1:0] factor;

  pdiv_factor #(
    .MAX_FACTOR    (MAX_FACTOR),
    .DEFAULT_FACTOR(DEFAULT_FACTOR)
  ) u_factor (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_lvl  (ctl_i.up),
    .down_lvl(ctl_i.down),
    .factor_o(factor)
  );

  pdiv_count #(
    .MAX_FACTOR(MAX_FACTOR)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_lvl  (ctl_i.pulse),
    .restart_lvl(ctl_i.restart),
    .factor_i   (factor),
    .out_o      (out_o)
  );

  assign factor_o = factor;
endmodule

// File: rtl/pdiv_dual.sv
module pdiv_dual
  import pdiv_pkg::*;
#(
  parameter int unsigned MAX_FACTOR     = 16,
  parameter int unsigned DEFAULT_FACTOR = 2,
  parameter int unsigned SYNC_STAGES    = 2,
  localparam int unsigned FW            = $clog2(MAX_FACTOR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_i,
  input  logic          b_pulse_patched_i,
  input  logic          b_reset_patched_i,
  input  logic          a_pulse_i,
  input  logic          a_reset_i,
  input  logic          a_up_i,
  input  logic          a_down_i,
  input  logic          b_pulse_i,
  input  logic          b_reset_i,
  input  logic          b_up_i,
  input  logic          b_down_i,
  output logic          a_out_o,
  output logic          b_out_o,
  output logic [FW-1:0] a_factor_o,
  output logic [FW-1:0] b_factor_o
);
  localparam int unsigned NCH = 2;

  logic [RAW_W-1:0] raw_lvl;
  logic [RAW_W-1:0] syn_lvl;
  pdiv_ctl_t        own_ctl [NCH];
  pdiv_ctl_t        ch_ctl  [NCH];
  logic [NCH-1:0]   ch_pulse;
  logic [NCH-1:0]   ch_reset;
  logic [NCH-1:0]   ch_out;
  logic [FW-1:0]    ch_factor [NCH];
  logic             link_s, ppatch_s, rpatch_s;

  assign raw_lvl = {b_reset_patched_i, b_pulse_patched_i, link_i,
                    b_down_i, b_up_i, b_reset_i, b_pulse_i,
                    a_down_i, a_up_i, a_reset_i, a_pulse_i};

  pdiv_sync #(
    .WIDTH (RAW_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_lvl),
    .q_o  (syn_lvl)
  );

  assign link_s   = syn_lvl[8];
  assign ppatch_s = syn_lvl[9];
  assign rpatch_s = syn_lvl[10];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_own
      assign own_ctl[c] = '{pulse:   syn_lvl[4*c],
                            restart: syn_lvl[4*c+1],
                            up:      syn_lvl[4*c+2],
                            down:    syn_lvl[4*c+3]};
    end
  endgenerate

  // Channel one always runs from its own inputs; channel two may borrow them
  always_comb begin
    ch_ctl[0] = own_ctl[0];
    ch_ctl[1] = own_ctl[1];
    if (link_s && !ppatch_s) ch_ctl[1].pulse   = own_ctl[0].pulse;
    if (link_s && !rpatch_s) ch_ctl[1].restart = own_ctl[0].restart;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_pulse[c] = ch_ctl[c].pulse;
      assign ch_reset[c] = ch_ctl[c].restart;
      pdiv_channel #(
        .MAX_FACTOR    (MAX_FACTOR),
        .DEFAULT_FACTOR(DEFAULT_FACTOR)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ch_ctl[c]),
        .out_o   (ch_out[c]),
        .factor_o(ch_factor[c])
      );
    end
  endgenerate

  assign a_out_o    = ch_out[0];
  assign b_out_o    = ch_out[1];
  assign a_factor_o = ch_factor[0];
  assign b_factor_o = ch_factor[1];
endmodule

// File: rtl/pdiv_dual_chk.sv
module pdiv_dual_chk #(
  parameter int unsigned MAX_FACTOR = 16,
  localparam int unsigned FW        = $clog2(MAX_FACTOR + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    plvl,
  input logic [1:0]    rlvl,
  input logic          a_out,
  input logic          b_out,
  input logic [FW-1:0] a_fac,
  input logic [FW-1:0] b_fac
);
  p_range_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fac >= FW'(1)) && (a_fac <= FW'(MAX_FACTOR)));
  p_range_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_fac >= FW'(1)) && (b_fac <= FW'(MAX_FACTOR)));

  p_step_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, a_fac} == {1'b0, $past(a_fac)}) ||
    ({1'b0, a_fac} == {1'b0, $past(a_fac)} + 1'b1) ||
    ({1'b0, a_fac} + 1'b1 == {1'b0, $past(a_fac)}));

  p_fall_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !plvl[0] |=> !a_out);
  p_fall_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !plvl[1] |=> !b_out);

  p_bypass_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fac == FW'(1) && plvl[0] && !$past(plvl[0])) |=> a_out);

  p_restart_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rlvl[0]) && plvl[0] && !$past(plvl[0])) |=> a_out);
  p_restart_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rlvl[1]) && plvl[1] && !$past(plvl[1])) |=> b_out);
endmodule

bind pdiv_dual pdiv_dual_chk #(.MAX_FACTOR(MAX_FACTOR)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .plvl (ch_pulse),
  .rlvl (ch_reset),
  .a_out(a_out_o),
  .b_out(b_out_o),
  .a_fac(a_factor_o),
  .b_fac(b_factor_o)
);

// File: tb/sim_pdiv_dual.sv
module sim_pdiv_dual;
  localparam int MAXF = 16;
  localparam int DEFF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_i = 0, pp_i = 0, rp_i = 0;
  logic a_p = 0, a_r = 0, a_u = 0, a_d = 0;
  logic b_p = 0, b_r = 0, b_u = 0, b_d = 0;
  logic a_out, b_out;
  logic [4:0] a_fac, b_fac;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int a_rises = 0, b_rises = 0;
  logic a_prev = 0, b_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pdiv_dual u0 (
    .clk(clk), .rst_n(rst_n), .link_i(link_i),
    .b_pulse_patched_i(pp_i), .b_reset_patched_i(rp_i),
    .a_pulse_i(a_p), .a_reset_i(a_r), .a_up_i(a_u), .a_down_i(a_d),
    .b_pulse_i(b_p), .b_reset_i(b_r), .b_up_i(b_u), .b_down_i(b_d),
    .a_out_o(a_out), .b_out_o(b_out), .a_factor_o(a_fac), .b_factor_o(b_fac)
  );

  // Behavioural reference: two delayed copies of the raw levels, then per-channel state
  logic [10:0] m_dly0 = '0, m_dly1 = '0;
  int m_fac[2], m_cnt[2];
  bit m_arm[2], m_gate[2], m_pprev[2], m_uprev[2], m_dprev[2];

  initial for (int c = 0; c < 2; c++) begin
    m_fac[c] = DEFF; m_cnt[c] = 0;
    m_arm[c] = 0; m_gate[c] = 0; m_pprev[c] = 0; m_uprev[c] = 0; m_dprev[c] = 0;
  end

  always @(posedge clk) begin
    bit p, r, u, d, pe, ue, de, first;
    int pos;
    if (!rst_n) begin
      m_dly0 = '0; m_dly1 = '0;
      for (int c = 0; c < 2; c++) begin
        m_fac[c] = DEFF; m_cnt[c] = 0;
        m_arm[c] = 0; m_gate[c] = 0; m_pprev[c] = 0; m_uprev[c] = 0; m_dprev[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        p = m_dly1[4*c]; r = m_dly1[4*c+1]; u = m_dly1[4*c+2]; d = m_dly1[4*c+3];
        if (c == 1 && m_dly1[8] && !m_dly1[9])  p = m_dly1[0];
        if (c == 1 && m_dly1[8] && !m_dly1[10]) r = m_dly1[1];
        pe = p && !m_pprev[c]; ue = u && !m_uprev[c]; de = d && !m_dprev[c];
        if (pe) begin
          pos = (m_arm[c] || m_cnt[c] >= m_fac[c]) ? 0 : m_cnt[c];
          first = (pos == 0);
          m_cnt[c] = (pos + 1 >= m_fac[c]) ? 0 : pos + 1;
          m_gate[c] = first;
        end else m_gate[c] = m_gate[c] && p;
        m_arm[c] = r || (m_arm[c] && !pe);
        if (ue && !de && m_fac[c] < MAXF) m_fac[c]++;
        else if (de && !ue && m_fac[c] > 1) m_fac[c]--;
        m_pprev[c] = p; m_uprev[c] = u; m_dprev[c] = d;
      end
      m_dly1 = m_dly0;
      m_dly0 = {rp_i, pp_i, link_i, b_d, b_u, b_r, b_p, a_d, a_u, a_r, a_p};
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model, plus edge counters for directed checks
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R2 a_out vs model", a_out, m_gate[0]);
      check("R8 b_out vs model", b_out, m_gate[1]);
      check("R4 a_factor vs model", a_fac, m_fac[0]);
      check("R4 b_factor vs model", b_fac, m_fac[1]);
    end
    if (a_out && !a_prev) a_rises++;
    if (b_out && !b_prev) b_rises++;
    a_prev = a_out; b_prev = b_out;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ch: 0 = A, 1 = B; with_rst raises the reset level together with the pulse
  task automatic pulse(int ch, int n, bit with_rst = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch == 0) begin a_p = 1; a_r = with_rst; end
      else         begin b_p = 1; b_r = with_rst; end
      idle(2);
      a_p = 0; b_p = 0; a_r = 0; b_r = 0;
      idle(4);
    end
  endtask

  task automatic restart(int ch);
    @(negedge clk);
    if (ch == 0) a_r = 1; else b_r = 1;
    idle(2);
    a_r = 0; b_r = 0;
    idle(2);
  endtask

  task automatic press(int ch, bit up, bit dn);
    @(negedge clk);
    if (ch == 0) begin a_u = up; a_d = dn; end
    else         begin b_u = up; b_d = dn; end
    idle(2);
    a_u = 0; a_d = 0; b_u = 0; b_d = 0;
    idle(3);
  endtask

  task automatic set_factor(int ch, int f);
    repeat (16) press(ch, 0, 1);
    repeat (f - 1) press(ch, 1, 0);
  endtask

  int a0, b0;

  initial begin
    idle(3);
    check("R11 a_out in reset", a_out, 0);
    check("R11 b_out in reset", b_out, 0);
    check("R1 a_factor default", a_fac, DEFF);
    check("R1 b_factor default", b_fac, DEFF);
    @(negedge clk); rst_n = 1;
    idle(3);

    a0 = a_rises; pulse(0, 8);
    check("R2 factor 2, 8 pulses", a_rises - a0, 4);

    press(0, 1, 0);
    check("R4 up step", a_fac, 3);
    a0 = a_rises; pulse(0, 9);
    check("R2 factor 3, 9 pulses", a_rises - a0, 3);

    press(0, 1, 1);
    check("R4 simultaneous up/down", a_fac, 3);

    press(0, 0, 1); press(0, 0, 1);
    check("R4 down step", a_fac, 1);
    a0 = a_rises; pulse(0, 5);
    check("R3 bypass passes all", a_rises - a0, 5);
    press(0, 0, 1);
    check("R5 floor at 1", a_fac, 1);
    repeat (20) press(0, 1, 0);
    check("R5 ceiling at 16", a_fac, 16);

    // Deferred restart
    set_factor(0, 4);
    restart(0); pulse(0, 1); pulse(0, 2);
    a0 = a_rises; restart(0);
    check("R6 restart does not act at once", a_rises - a0, 0);
    pulse(0, 1);
    check("R6 first pulse after restart output", a_rises - a0, 1);
    a0 = a_rises; pulse(0, 3);
    check("R6 count resumes after restart", a_rises - a0, 0);
    pulse(0, 1);
    check("R6 group completes", a_rises - a0, 1);

    // Factor lowered under the count
    set_factor(0, 5);
    restart(0); pulse(0, 4);
    press(0, 0, 1); press(0, 0, 1); press(0, 0, 1);
    a0 = a_rises; pulse(0, 1);
    check("R7 lowered factor outputs next pulse", a_rises - a0, 1);

    // Reset and pulse edge in the same cycle
    set_factor(0, 3);
    restart(0); pulse(0, 1);
    a0 = a_rises; pulse(0, 1, 1);
    check("R10 coincident pulse uses prior state", a_rises - a0, 0);
    pulse(0, 1);
    check("R10 coincident reset armed restart", a_rises - a0, 1);

    // Link
    set_factor(1, 1);
    @(negedge clk); link_i = 1; idle(4);
    b0 = b_rises; pulse(0, 4);
    check("R8 linked B follows A pulses", b_rises - b0, 4);
    b0 = b_rises; pulse(1, 3);
    check("R8 own B pulses ignored while linked", b_rises - b0, 0);
    set_factor(1, 3);
    restart(1); pulse(0, 1);
    b0 = b_rises; restart(0); pulse(0, 1);
    check("R8 A reset restarts linked B", b_rises - b0, 1);

    // Per-input override
    @(negedge clk); pp_i = 1; idle(4);
    set_factor(1, 1);
    b0 = b_rises; pulse(0, 3);
    check("R9 patched B ignores A pulses", b_rises - b0, 0);
    pulse(1, 2);
    check("R9 patched B uses own pulses", b_rises - b0, 2);
    set_factor(1, 3);
    pulse(1, 1);
    b0 = b_rises; restart(0); pulse(1, 1);
    check("R9 unpatched reset still linked", b_rises - b0, 1);
    @(negedge clk); rp_i = 1; idle(4);
    pulse(1, 1);
    b0 = b_rises; restart(0); pulse(1, 1);
    check("R9 patched reset ignores A reset", b_rises - b0, 0);

    @(negedge clk); rst_n = 0; idle(2);
    check("R11 reset restores default", a_fac, DEFF);
    check("R11 reset clears out", a_out, 0);
    @(negedge clk); rst_n = 1; idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule